// File: doc/BRIEF.md
# Per-Frame Cable Detect Power Controller

This block decides, once per video frame, whether a cable is attached to each of up to two monitored video DACs. It also decides whether the three DAC outputs may draw power for the rest of that frame. A load-sense comparator per DAC is sampled on a frame-start strobe. The result is held in a two-bit status word. A status bit of 0 means a load was seen and 1 means none was seen. When automatic power-off is enabled, a DAC that found no load switches off its DAC or DACs until the next frame's check, which powers them up again if a cable has appeared.

The output format decides both which DACs are watched and which are switched off. In composite/S-video format, DAC 1 and DAC 2 are both watched. A missing load on DAC 1 turns off DAC 1 alone. A missing load on DAC 2 turns off DAC 2 and DAC 3. In component or RGB format only DAC 1 is watched, and a missing load on it turns off all three. Detection is meaningful only in full-drive mode and only for a DAC that the main power configuration has switched on. In every other case the status reads 1 and the power enables follow the main configuration.

Top module: `cable_det_pwr`

## Requirements
- R1: After reset, link_stat reads 2'b11 and dac_pwr equals dac_on_cfg, whatever the other inputs are, until the first frame_start.
- R2: On a clock edge with frame_start high, each watched DAC's status bit takes the inverse of its load_sense bit. Bit 0 belongs to DAC 1 and bit 1 to DAC 2, so 0 means connected. The new value is visible after that edge.
- R3: When comp_fmt is 1 (component/RGB), link_stat[1] reads 1 and load_sense[1] has no effect on any output.
- R4: Between strobes, with the configuration unchanged, link_stat and dac_pwr hold their values even when load_sense changes.
- R5: When det_en is 0 or full_drive is 0, link_stat reads 2'b11 and dac_pwr equals dac_on_cfg.
- R6: A DAC whose dac_on_cfg bit is 0 is not watched. Its status bit reads 1 and it never causes another DAC to power off.
- R7: In composite/S-video format (comp_fmt 0), with auto_off_en 1, DAC 1 missing a load clears dac_pwr[0] only. DAC 2 missing a load clears dac_pwr[2:1].
- R8: In component/RGB format (comp_fmt 1), with auto_off_en 1, DAC 1 missing a load clears all of dac_pwr.
- R9: With auto_off_en 0, dac_pwr equals dac_on_cfg, and no enable is ever high whose dac_on_cfg bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| load_sense | input | 2 | Comparator outputs, 1 = load present; bit 0 DAC 1, bit 1 DAC 2 |
| det_en | input | 1 | Cable detection enable |
| auto_off_en | input | 1 | Automatic power-off enable |
| comp_fmt | input | 1 | 0 = composite/S-video, 1 = component/RGB |
| full_drive | input | 1 | 1 = full-drive DAC mode, 0 = low-drive |
| dac_on_cfg | input | 3 | Main per-DAC power configuration |
| link_stat | output | 2 | Connection status, 0 = cable detected |
| dac_pwr | output | 3 | Per-DAC power enable |

## Verification
The block has no parameters, so the bench builds it as it stands and walks the complete input space. That space is every combination of the seven configuration bits with each of the four load-sense patterns, 512 frames in all. Every frame is checked right after its strobe, and again after the sense inputs are flipped without a strobe. The second check catches stale or leaky holding. The exhaustive sweep covers the cases where format, drive mode and per-DAC configuration interact, and that is where mistakes in the power-off mapping would show.

// File: rtl/cable_det_pwr.sv
module cable_det_pwr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [1:0] load_sense,
  input  logic       det_en,
  input  logic       auto_off_en,
  input  logic       comp_fmt,
  input  logic       full_drive,
  input  logic [2:0] dac_on_cfg,
  output logic [1:0] link_stat,
  output logic [2:0] dac_pwr
);

  logic       det_ok;
  logic [1:0] watch;
  logic [1:0] miss_q;
  logic       seen_q;
  logic [1:0] cut;

  assign det_ok   = det_en & full_drive;
  assign watch[0] = det_ok & dac_on_cfg[0];
  assign watch[1] = det_ok & ~comp_fmt & dac_on_cfg[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_q <= 2'b11;
      seen_q <= 1'b0;
    end else if (frame_start) begin
      miss_q <= ~load_sense | ~watch;
      seen_q <= 1'b1;
    end
  end

  assign link_stat = miss_q | ~watch;
  assign cut       = {2{seen_q & auto_off_en}} & watch & miss_q;

  assign dac_pwr[0] = dac_on_cfg[0] & ~cut[0];
  assign dac_pwr[1] = dac_on_cfg[1] & ~(comp_fmt ? cut[0] : cut[1]);
  assign dac_pwr[2] = dac_on_cfg[2] & ~(comp_fmt ? cut[0] : cut[1]);

endmodule

module cable_det_pwr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       det_en,
  input logic       auto_off_en,
  input logic       comp_fmt,
  input logic       full_drive,
  input logic [2:0] dac_on_cfg,
  input logic [1:0] link_stat,
  input logic [2:0] dac_pwr
);

  // R4
  hold_between_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(frame_start) && $past(rst_n) &&
     $stable({det_en, auto_off_en, comp_fmt, full_drive, dac_on_cfg}))
    |-> ($stable(link_stat) && $stable(dac_pwr)));

  // R5
  invalid_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(det_en && full_drive) |-> (link_stat == 2'b11 && dac_pwr == dac_on_cfg));

  // R3
  comp_dac2_unwatched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comp_fmt |-> link_stat[1]);

  // R9
  no_auto_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_off_en |-> dac_pwr == dac_on_cfg);

  // R9
  pwr_within_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_pwr & ~dac_on_cfg) == 3'b000);

  // R8
  comp_all_or_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comp_fmt |-> (dac_pwr == 3'b000 || dac_pwr == dac_on_cfg));

  // R7
  cvbs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!comp_fmt && dac_on_cfg[2:1] == 2'b11) |-> (dac_pwr[1] == dac_pwr[2]));

endmodule

bind cable_det_pwr cable_det_pwr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
  .det_en(det_en), .auto_off_en(auto_off_en), .comp_fmt(comp_fmt),
  .full_drive(full_drive), .dac_on_cfg(dac_on_cfg),
  .link_stat(link_stat), .dac_pwr(dac_pwr)
);

// File: tb/tb_cable_det_pwr.sv
module tb_cable_det_pwr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic [1:0] load_sense = 2'b00;
  logic       det_en = 1'b1;
  logic       auto_off_en = 1'b1;
  logic       comp_fmt = 1'b0;
  logic       full_drive = 1'b1;
  logic [2:0] dac_on_cfg = 3'b111;
  logic [1:0] link_stat;
  logic [2:0] dac_pwr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cable_det_pwr dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .load_sense(load_sense),
    .det_en(det_en), .auto_off_en(auto_off_en), .comp_fmt(comp_fmt),
    .full_drive(full_drive), .dac_on_cfg(dac_on_cfg),
    .link_stat(link_stat), .dac_pwr(dac_pwr)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state with auto-off enabled and no loads
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 stat", link_stat, 2'b11);
    check("R1 pwr", dac_pwr, 3'b111);
    dac_on_cfg = 3'b101;
    @(negedge clk);
    check("R1 pwr cfg", dac_pwr, 3'b101);

    for (int c = 0; c < 128; c++) begin
      for (int s = 0; s < 4; s++) begin
        logic ok, w0, w1, m0, m1, apd, cf;
        logic [1:0] es;
        logic [2:0] ep, cfg;
        string ts, tp;
        det_en = c[0]; auto_off_en = c[1]; comp_fmt = c[2]; full_drive = c[3];
        dac_on_cfg = c[6:4];
        load_sense = s[1:0];
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        cfg = c[6:4]; apd = c[1]; cf = c[2];
        ok = c[0] & c[3];
        w0 = ok & cfg[0];
        w1 = ok & !cf & cfg[1];
        m0 = w0 ? !s[0] : 1'b1;
        m1 = w1 ? !s[1] : 1'b1;
        es = {m1, m0};
        ep = cfg;
        if (apd && w0 && m0) ep = cf ? 3'b000 : (ep & 3'b110);
        if (apd && w1 && m1) ep = ep & 3'b001;
        if (!ok) begin ts = "R5 stat"; tp = "R5 pwr"; end
        else if (!cfg[0]) begin ts = "R6 stat"; tp = "R6 pwr"; end
        else if (cf) begin ts = "R3 stat"; tp = apd ? "R8 pwr" : "R9 pwr"; end
        else begin ts = "R2 stat"; tp = apd ? "R7 pwr" : "R9 pwr"; end
        check(ts, link_stat, es);
        check(tp, dac_pwr, ep);
        load_sense = ~s[1:0];
        repeat (2) @(negedge clk);
        check("R4 stat hold", link_stat, es);
        check("R4 pwr hold", dac_pwr, ep);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule